// File: doc/BRIEF.md
# Multi-Cycle Accumulator Load Sequencer

This block is a small multi-cycle processor core. It executes a narrow slice of an 8-bit accumulator instruction set from a byte-wide synchronous memory. It holds an accumulator, a 16-bit index register, a 16-bit program counter, an instruction register and an effective-address register.

Each instruction moves through a fixed order of phases: opcode fetch, decode, operand fetch, address evaluation and data read. One memory read is issued per bus cycle. The data for a read appears on the read-data port one clock after its address is presented.

The supported set is one clear instruction and one load instruction in four addressing modes: immediate, direct page, extended and zero-offset indexed. An unconditional branch with a PC-relative 8-bit displacement is also supported. A one-clock retire strobe marks the end of every instruction, so a reference model can compare the architectural state at that point. Any opcode outside the set stops the core until reset.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is held, the core shows PC equal to the START_ADDR parameter, A = 0, X = 0, Z = 1, N = 0, the illegal flag low and the retire strobe low.
- R2: Opcode 0x87 takes no operand and sets A to zero. It retires 2 cycles after the previous retire, with PC advanced by 1.
- R3: Opcode 0x86 loads A with the byte that follows the opcode. It takes 3 cycles, and PC advances by 2.
- R4: Opcode 0x96 uses its one operand byte as an address in the range 0x0000..0x00FF, with the high byte zero, and loads A from that address. It takes 5 cycles, and PC advances by 2.
- R5: Opcode 0xB6 reads two operand bytes, most significant first, to form a 16-bit address, and loads A from that address. It takes 6 cycles, and PC advances by 3.
- R6: Opcode 0xA6 followed by 0x00 loads A from the address held in X. It takes 5 cycles, and PC advances by 2.
- R7: Opcode 0x20 with operand rr sets PC to (branch address + 2 + sign-extended rr) and leaves A unchanged. It takes 3 cycles. For example, 0x20 0xFE branches to itself.
- R8: After each clear or load, Z is 1 exactly when A is zero, and N equals bit 7 of A. A branch leaves Z and N unchanged.
- R9: The retire strobe is high for exactly one clock per instruction. In that clock, A, PC, Z and N already show the instruction's result. A changes only in a clock where the strobe is high.
- R10: An opcode byte outside {0x87, 0x86, 0x96, 0xB6, 0xA6, 0x20} sets the illegal flag. The flag stays set until reset. From then on PC and A are frozen and no further retire strobe occurs. PC is left at opcode address + 1.
- R11: An indexed load whose postbyte is not 0x00 sets the illegal flag and halts the core in the same way as R10. PC is left at opcode address + 2.
- R12: The core never writes memory: the write enable stays low and the write data stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | ADDR_W | Memory read address for the current bus cycle |
| mem_rdata | input | DATA_W | Byte read from the address presented one clock earlier |
| mem_wdata | output | DATA_W | Memory write data, always zero |
| mem_we | output | 1 | Memory write enable, always low |
| acc_a | output | DATA_W | Accumulator A |
| idx_x | output | ADDR_W | Index register X |
| pc_o | output | ADDR_W | Program counter |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| instr_done | output | 1 | One-clock retire strobe at the end of each instruction |
| illegal_op | output | 1 | Sticky flag for an undefined opcode or postbyte |

## Verification
Each result is due a fixed number of clocks after the previous retire: 2 for the clear, 3 for an immediate load or a branch, 5 for a direct or indexed load, and 6 for an extended load. The first instruction after reset is the only exception. The scoreboard measures the distance between successive retire strobes and compares it with the expected count for the instruction that is retiring. It compares A, Z, N and PC on the falling edge inside the strobe clock. The halt cases are checked some clocks after the offending byte has been fetched. At that point the bench also confirms that PC and A stay frozen over a further interval.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPND1,
    ST_OPND2,
    ST_READ,
    ST_DATA,
    ST_HALT
  } seq_state_e;

  typedef enum logic [0:0] {
    ADDR_PC  = 1'b0,
    ADDR_EAR = 1'b1
  } addr_sel_e;

  localparam logic [7:0] OP_CLRA    = 8'h87;
  localparam logic [7:0] OP_LDA_IMM = 8'h86;
  localparam logic [7:0] OP_LDA_DIR = 8'h96;
  localparam logic [7:0] OP_LDA_EXT = 8'hB6;
  localparam logic [7:0] OP_LDA_IDX = 8'hA6;
  localparam logic [7:0] OP_BRA     = 8'h20;
  localparam logic [7:0] POST_IDX0  = 8'h00;

  typedef struct packed {
    logic      ir_ld;
    logic      pc_inc;
    logic      pc_rel;
    logic      a_clr;
    logic      a_ld;
    logic      ear_dir;
    logic      ear_hi;
    logic      ear_lo;
    logic      ear_idx;
    addr_sel_e addr_sel;
    logic      retire;
  } seq_ctl_t;

endpackage

// File: rtl/acc_seq_rst_sync.sv
module acc_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] ir_i,
  output seq_ctl_t          ctl_o,
  output logic              illegal_o
);

  seq_state_e state_q, state_d;
  logic       illegal_q, illegal_d;

  // next-state and control decode
  always_comb begin
    state_d   = state_q;
    illegal_d = illegal_q;
    ctl_o     = '0;
    case (state_q)
      ST_FETCH: begin
        ctl_o.pc_inc = 1'b1;
        state_d      = ST_DECODE;
      end
      ST_DECODE: begin
        ctl_o.ir_ld = 1'b1;
        case (rdata_i)
          OP_CLRA: begin
            ctl_o.a_clr  = 1'b1;
            ctl_o.retire = 1'b1;
            state_d      = ST_FETCH;
          end
          OP_LDA_IMM, OP_LDA_DIR, OP_LDA_EXT, OP_LDA_IDX, OP_BRA: begin
            ctl_o.pc_inc = 1'b1;
            state_d      = ST_OPND1;
          end
          default: begin
            illegal_d = 1'b1;
            state_d   = ST_HALT;
          end
        endcase
      end
      ST_OPND1: begin
        case (ir_i)
          OP_LDA_IMM: begin
            ctl_o.a_ld   = 1'b1;
            ctl_o.retire = 1'b1;
            state_d      = ST_FETCH;
          end
          OP_LDA_DIR: begin
            ctl_o.ear_dir = 1'b1;
            state_d       = ST_READ;
          end
          OP_LDA_EXT: begin
            ctl_o.ear_hi = 1'b1;
            ctl_o.pc_inc = 1'b1;
            state_d      = ST_OPND2;
          end
          OP_LDA_IDX: begin
            if (rdata_i == POST_IDX0) begin
              ctl_o.ear_idx = 1'b1;
              state_d       = ST_READ;
            end else begin
              illegal_d = 1'b1;
              state_d   = ST_HALT;
            end
          end
          OP_BRA: begin
            ctl_o.pc_rel = 1'b1;
            ctl_o.retire = 1'b1;
            state_d      = ST_FETCH;
          end
          default: begin
            illegal_d = 1'b1;
            state_d   = ST_HALT;
          end
        endcase
      end
      ST_OPND2: begin
        ctl_o.ear_lo = 1'b1;
        state_d      = ST_READ;
      end
      ST_READ: begin
        ctl_o.addr_sel = ADDR_EAR;
        state_d        = ST_DATA;
      end
      ST_DATA: begin
        ctl_o.a_ld   = 1'b1;
        ctl_o.retire = 1'b1;
        state_d      = ST_FETCH;
      end
      default: begin
        state_d = ST_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FETCH;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= illegal_d;
    end
  end

  assign illegal_o = illegal_q;

endmodule

// File: rtl/acc_seq_addr_mux.sv
module acc_seq_addr_mux
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_sel_e         sel_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ear_i,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    case (sel_i)
      ADDR_EAR: addr_o = ear_i;
      default:  addr_o = pc_i;
    endcase
  end

endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  seq_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ear_o,
  output logic              z_o,
  output logic              n_o,
  output logic              done_o
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] ir_q, acc_q;
  logic [ADDR_W-1:0] x_q, pc_q, ear_q, pc_d, ear_d;
  logic              z_q, n_q, done_q;
  logic [ADDR_W-1:0] disp_sext;

  assign disp_sext = {{EXT_W{rdata_i[DATA_W-1]}}, rdata_i};

  // PC next value
  always_comb begin
    pc_d = pc_q;
    if (ctl_i.pc_inc)      pc_d = pc_q + ADDR_W'(1);
    else if (ctl_i.pc_rel) pc_d = pc_q + disp_sext;
  end

  // effective address next value
  always_comb begin
    ear_d = ear_q;
    if (ctl_i.ear_dir)      ear_d = {{EXT_W{1'b0}}, rdata_i};
    else if (ctl_i.ear_idx) ear_d = x_q;
    else if (ctl_i.ear_hi)  ear_d = {rdata_i, ear_q[EXT_W-1:0]};
    else if (ctl_i.ear_lo)  ear_d = {ear_q[ADDR_W-1:DATA_W], rdata_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= START_ADDR;
      ear_q <= '0;
      ir_q  <= '0;
      x_q   <= '0;
    end else begin
      if (ctl_i.pc_inc || ctl_i.pc_rel) pc_q <= pc_d;
      if (ctl_i.ear_dir || ctl_i.ear_idx || ctl_i.ear_hi || ctl_i.ear_lo) ear_q <= ear_d;
      if (ctl_i.ir_ld) ir_q <= rdata_i;
      x_q <= x_q;
    end
  end

  // accumulator and flags
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      z_q   <= 1'b1;
      n_q   <= 1'b0;
    end else if (ctl_i.a_clr) begin
      acc_q <= '0;
      z_q   <= 1'b1;
      n_q   <= 1'b0;
    end else if (ctl_i.a_ld) begin
      acc_q <= rdata_i;
      z_q   <= (rdata_i == '0);
      n_q   <= rdata_i[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= ctl_i.retire;
  end

  assign ir_o   = ir_q;
  assign acc_o  = acc_q;
  assign x_o    = x_q;
  assign pc_o   = pc_q;
  assign ear_o  = ear_q;
  assign z_o    = z_q;
  assign n_o    = n_q;
  assign done_o = done_q;

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] acc_a,
  output logic [ADDR_W-1:0] idx_x,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flag_z,
  output logic              flag_n,
  output logic              instr_done,
  output logic              illegal_op
);

  logic              rst_int_n;
  seq_ctl_t          ctl;
  logic [DATA_W-1:0] ir;
  logic [ADDR_W-1:0] ear;

  acc_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  acc_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .rdata_i   (mem_rdata),
    .ir_i      (ir),
    .ctl_o     (ctl),
    .illegal_o (illegal_op)
  );

  acc_seq_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata),
    .ir_o    (ir),
    .acc_o   (acc_a),
    .x_o     (idx_x),
    .pc_o    (pc_o),
    .ear_o   (ear),
    .z_o     (flag_z),
    .n_o     (flag_n),
    .done_o  (instr_done)
  );

  acc_seq_addr_mux #(.ADDR_W(ADDR_W)) u_amux (
    .sel_i  (ctl.addr_sel),
    .pc_i   (pc_o),
    .ear_i  (ear),
    .addr_o (mem_addr)
  );

  assign mem_wdata = '0;
  assign mem_we    = 1'b0;

endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] acc_a,
  input logic [ADDR_W-1:0] pc_o,
  input logic              flag_z,
  input logic              flag_n,
  input logic              instr_done,
  input logic              illegal_op
);

  // R9
  retire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  // R9
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |-> $stable(acc_a));

  // R8
  flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_z == (acc_a == '0)) && (flag_n == acc_a[DATA_W-1]));

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> illegal_op);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> ($stable(pc_o) && $stable(acc_a) && !instr_done));

endmodule

bind acc_seq_core acc_seq_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_a      (acc_a),
  .pc_o       (pc_o),
  .flag_z     (flag_z),
  .flag_n     (flag_n),
  .instr_done (instr_done),
  .illegal_op (illegal_op)
);

// File: tb/acc_seq_core_bench.sv
`timescale 1ns/1ps
module acc_seq_core_bench;

  localparam int          AW    = 16;
  localparam int          DW    = 8;
  localparam logic [15:0] START = 16'h0100;

  typedef struct {
    logic [7:0]  a;
    logic        z;
    logic        n;
    logic [15:0] pc;
    int          cyc;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] acc_a;
  logic [AW-1:0] idx_x;
  logic [AW-1:0] pc_o;
  logic          flag_z, flag_n, instr_done, illegal_op;

  logic [7:0] mem [0:4095];
  exp_t       sb_q[$];
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc_now = 0;
  int         last_done = 0;
  bit         have_prev = 0;
  bit         prev_done = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  acc_seq_core #(.ADDR_W(AW), .DATA_W(DW), .START_ADDR(START)) u_acc_seq_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .acc_a(acc_a), .idx_x(idx_x),
    .pc_o(pc_o), .flag_z(flag_z), .flag_n(flag_n), .instr_done(instr_done),
    .illegal_op(illegal_op)
  );

  always @(posedge clk) mem_rdata <= mem[mem_addr[11:0]];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] addr, input logic [7:0] val);
    mem[addr[11:0]] = val;
  endtask

  task automatic expect_item(input logic [7:0] a, input logic z, input logic n,
                             input logic [15:0] pc, input int cyc, input string tag);
    exp_t e;
    e.a = a; e.z = z; e.n = n; e.pc = pc; e.cyc = cyc; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc_now++;
    if (!rst_n) begin
      have_prev = 0;
    end else if (instr_done) begin
      chk(!prev_done, "R9", "strobe width", 1, 0);
      chk(mem_we == 1'b0 && mem_wdata == 8'h00, "R12", "write port",
          {mem_we, mem_wdata}, 0);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected retire", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(acc_a == e.a, e.tag, "acc", acc_a, e.a);
        chk(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
        chk({flag_z, flag_n} == {e.z, e.n}, "R8", "flags z,n", {flag_z, flag_n}, {e.z, e.n});
        if (have_prev && e.cyc != 0)
          chk(cyc_now - last_done == e.cyc, e.tag, "cycles", cyc_now - last_done, e.cyc);
      end
      last_done = cyc_now;
      have_prev = 1;
    end
    prev_done = instr_done;
  end

  initial begin
    logic [15:0] pc_hold;
    // run 1: legal program
    hold_reset();
    chk(pc_o == START, "R1", "reset pc", pc_o, START);
    chk(acc_a == 8'h00 && idx_x == 16'h0000, "R1", "reset A/X", {acc_a, idx_x}, 0);
    chk(flag_z && !flag_n, "R1", "reset flags", {flag_z, flag_n}, 2);
    chk(!illegal_op && !instr_done, "R1", "reset strobes", {illegal_op, instr_done}, 0);
    put(16'h0100, 8'h86); put(16'h0101, 8'h55);
    put(16'h0102, 8'h87);
    put(16'h0103, 8'h96); put(16'h0104, 8'h40);
    put(16'h0105, 8'h20); put(16'h0106, 8'h02);
    put(16'h0107, 8'h87); put(16'h0108, 8'h87);
    put(16'h0109, 8'hB6); put(16'h010A, 8'h0A); put(16'h010B, 8'h10);
    put(16'h010C, 8'hA6); put(16'h010D, 8'h00);
    put(16'h010E, 8'h86); put(16'h010F, 8'h7F);
    put(16'h0110, 8'h20); put(16'h0111, 8'h03);
    put(16'h0112, 8'h87); put(16'h0113, 8'h87); put(16'h0114, 8'h87);
    put(16'h0115, 8'h86); put(16'h0116, 8'h00);
    put(16'h0117, 8'h20); put(16'h0118, 8'hFE);
    put(16'h0040, 8'h9C);
    put(16'h0A10, 8'h00);
    put(16'h000A, 8'h5A);
    put(16'h0010, 8'h33);
    put(16'h0000, 8'h80);
    expect_item(8'h55, 0, 0, 16'h0102, 0, "R3");
    expect_item(8'h00, 1, 0, 16'h0103, 2, "R2");
    expect_item(8'h9C, 0, 1, 16'h0105, 5, "R4");
    expect_item(8'h9C, 0, 1, 16'h0109, 3, "R7");
    expect_item(8'h00, 1, 0, 16'h010C, 6, "R5");
    expect_item(8'h80, 0, 1, 16'h010E, 5, "R6");
    expect_item(8'h7F, 0, 0, 16'h0110, 3, "R3");
    expect_item(8'h7F, 0, 0, 16'h0115, 3, "R7");
    expect_item(8'h00, 1, 0, 16'h0117, 3, "R3");
    expect_item(8'h00, 1, 0, 16'h0117, 3, "R7");
    expect_item(8'h00, 1, 0, 16'h0117, 3, "R7");
    rst_n = 1'b1;
    wait (sb_q.size() == 0);

    // run 2: bad indexed postbyte
    hold_reset();
    put(16'h0100, 8'hA6); put(16'h0101, 8'h01);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(illegal_op, "R11", "illegal flag", illegal_op, 1);
    chk(pc_o == 16'h0102, "R11", "halt pc", pc_o, 16'h0102);
    chk(!have_prev, "R11", "no retire", have_prev, 0);

    // run 3: undefined opcode after a load
    hold_reset();
    put(16'h0100, 8'h86); put(16'h0101, 8'h12);
    put(16'h0102, 8'h55);
    expect_item(8'h12, 0, 0, 16'h0102, 0, "R3");
    rst_n = 1'b1;
    wait (sb_q.size() == 0);
    repeat (10) @(negedge clk);
    chk(illegal_op, "R10", "illegal flag", illegal_op, 1);
    chk(pc_o == 16'h0103, "R10", "halt pc", pc_o, 16'h0103);
    pc_hold = pc_o;
    repeat (10) @(negedge clk);
    chk(illegal_op && pc_o == pc_hold && acc_a == 8'h12, "R10", "frozen state",
        {illegal_op, pc_o, acc_a}, {1'b1, pc_hold, 8'h12});

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule